// File: doc/BRIEF.md
# Packed Palette Loader

This block holds a 256-entry colour lookup table (8-bit red, green and blue per entry) and fills it from a stream of 32-bit register writes in which the colour bytes are packed back to back without regard to entry boundaries. Software writes a starting entry to the pointer location, then writes colour words to the data location. Every three words carry twelve bytes, which is exactly four entries. Bytes keep their red, green, blue order throughout. A running cursor tracks where the next byte lands, including the byte or two of an entry that spills into the following word.

A display pipeline reads the table through a separate pixel port: an 8-bit index in, the 24-bit colour out one cycle later. The pointer location also selects one of four byte-wide configuration registers, which are written through the control location. Any write to the cursor location is accepted and discarded.

The write side is a valid/ready channel. `wr_ready` is held high, so the block never applies back-pressure. A write takes effect in the cycle where `wr_valid` is high at a rising clock edge. The pixel and configuration read ports are plain signals.

Top module: `clut_pack_loader`

## Requirements
- R1: After reset every table entry reads as 0x000000, and the four configuration registers (pointer values 4, 5, 6, 7) read 0xFF, 0x00, 0x70 and 0x00.
- R2: After a pointer write, three data words fill entries base, base+1, base+2 and base+3. Each word's bytes are taken most significant first. The twelve bytes map, in order, to R,G,B of base, then R,G,B of base+1, and so on. `pix_rgb` carries red in bits 23:16, green in 15:8 and blue in 7:0.
- R3: The group base is the written pointer value with its two low bits forced to zero.
- R4: After the third word of a group the base advances by four, modulo 256. Further data words continue into the next group without a new pointer write.
- R5: A pointer write returns the byte cursor to the start of a group. Entries of the interrupted group that had not yet received all three bytes keep their previous contents.
- R6: An entry changes only in the write that delivers its last byte. The first word updates only base, the second only base+1, and the third updates base+2 and base+3.
- R7: `pix_rgb` shows the entry selected by `pix_idx` at the previous rising edge, one cycle of latency.
- R8: A control write with pointer 4 to 7 loads `wr_data[7:0]` into that configuration register. With any other pointer value the control write changes nothing.
- R9: Writes to the cursor location (`wr_sel`=3), and any cycle with `wr_valid` low, change neither the table, the configuration registers nor the byte cursor. `wr_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accept, always 1 |
| wr_sel | input | 2 | Location: 0 pointer, 1 colour data, 2 control, 3 cursor |
| wr_data | input | 32 | Write data |
| pix_idx | input | 8 | Pixel index for lookup |
| pix_rgb | output | 24 | Colour of the entry indexed at the previous edge |
| cfg_sel | input | 2 | Selects configuration register 4+cfg_sel |
| cfg_q | output | 8 | Selected configuration register value |

## Verification
If the byte cursor slips by even one position, every later entry in the stream comes out with its components rotated. This shows on `pix_rgb` one cycle after the affected index is presented. A wrong group base or a missing advance puts a whole group at the wrong indices, which a full sweep of the table exposes. A cursor left mid-group after a pointer write corrupts the very next committed entry. An entry written too early shows stale bytes inside a single word's window. A wrong control decode shows at once on `cfg_q`.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef enum logic [1:0] {
    LOC_PTR  = 2'd0,
    LOC_DATA = 2'd1,
    LOC_CTL  = 2'd2,
    LOC_CURS = 2'd3
  } loc_e;

  function automatic logic [7:0] cfg_reset_val(input int i);
    case (i)
      0:       cfg_reset_val = 8'hFF;
      1:       cfg_reset_val = 8'h00;
      2:       cfg_reset_val = 8'h70;
      default: cfg_reset_val = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/clut_unpack.sv
module clut_unpack #(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ptr_we,
  input  logic [IDX_W-1:0]      ptr_d,
  input  logic                  data_we,
  input  logic [4*CH_W-1:0]     data_d,
  output logic                  a_en,
  output logic [IDX_W-1:0]      a_idx,
  output logic [3*CH_W-1:0]     a_rgb,
  output logic                  b_en,
  output logic [IDX_W-1:0]      b_idx,
  output logic [3*CH_W-1:0]     b_rgb
);
  localparam int BW = 4 * CH_W;

  logic [1:0]       phase;
  logic [IDX_W-1:0] base;
  logic [CH_W-1:0]  held0, held1;
  logic [CH_W-1:0]  y0, y1, y2, y3;

  assign y0 = data_d[BW-1        -: CH_W];
  assign y1 = data_d[BW-1-CH_W   -: CH_W];
  assign y2 = data_d[BW-1-2*CH_W -: CH_W];
  assign y3 = data_d[CH_W-1:0];

  always_comb begin
    a_en  = data_we;
    a_idx = base + IDX_W'(phase);
    b_en  = data_we && (phase == 2'd2);
    b_idx = base + IDX_W'(3);
    b_rgb = {y1, y2, y3};
    case (phase)
      2'd0:    a_rgb = {y0, y1, y2};
      2'd1:    a_rgb = {held0, y0, y1};
      default: a_rgb = {held0, held1, y0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 2'd0;
      base  <= '0;
      held0 <= '0;
      held1 <= '0;
    end else if (ptr_we) begin
      phase <= 2'd0;
      base  <= {ptr_d[IDX_W-1:2], 2'b00};
    end else if (data_we) begin
      case (phase)
        2'd0: begin
          held0 <= y3;
          phase <= 2'd1;
        end
        2'd1: begin
          held0 <= y2;
          held1 <= y3;
          phase <= 2'd2;
        end
        default: begin
          phase <= 2'd0;
          base  <= base + IDX_W'(4);
        end
      endcase
    end
  end

  p_phase_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

  p_pair_adjacent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    b_en |-> (a_en && (b_idx == a_idx + IDX_W'(1))));

  p_group_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !ptr_we && phase == 2'd2) |=> (base == $past(base) + IDX_W'(4)) && (phase == 2'd0));

  p_ptr_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> (phase == 2'd0) && (base[1:0] == 2'b00));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_we && !data_we) |=> $stable(phase) && $stable(base));

endmodule

// File: rtl/clut_table.sv
module clut_table #(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  a_en,
  input  logic [IDX_W-1:0]      a_idx,
  input  logic [3*CH_W-1:0]     a_rgb,
  input  logic                  b_en,
  input  logic [IDX_W-1:0]      b_idx,
  input  logic [3*CH_W-1:0]     b_rgb,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [3*CH_W-1:0]     rd_rgb
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [3*CH_W-1:0] mem [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (a_en && a_idx == IDX_W'(i))
        mem[i] <= a_rgb;
      else if (b_en && b_idx == IDX_W'(i))
        mem[i] <= b_rgb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_rgb <= '0;
    else        rd_rgb <= mem[rd_idx];
  end

  p_ports_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && b_en) |-> (a_idx != b_idx));

endmodule

// File: rtl/clut_cfg.sv
module clut_cfg #(
  parameter int IDX_W    = 8,
  parameter int CFG_BASE = 4,
  parameter int CFG_N    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           ptr,
  input  logic [7:0]                 d,
  input  logic [$clog2(CFG_N)-1:0]   rd_sel,
  output logic [7:0]                 rd_q
);
  import clut_pkg::*;

  logic [CFG_N-1:0][7:0] regs;
  logic                  hit;

  assign hit  = (int'(ptr) >= CFG_BASE) && (int'(ptr) < CFG_BASE + CFG_N);
  assign rd_q = regs[rd_sel];

  for (genvar i = 0; i < CFG_N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= cfg_reset_val(i);
      else if (we && hit && int'(ptr) == CFG_BASE + i)
        regs[i] <= d;
    end
  end

  p_miss_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit) |=> $stable(regs));

  p_no_write_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs));

endmodule

// File: rtl/clut_pack_loader.sv
module clut_pack_loader #(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [1:0]           wr_sel,
  input  logic [4*CH_W-1:0]    wr_data,
  input  logic [IDX_W-1:0]     pix_idx,
  output logic [3*CH_W-1:0]    pix_rgb,
  input  logic [1:0]           cfg_sel,
  output logic [7:0]           cfg_q
);
  import clut_pkg::*;

  logic             fire, ptr_we, data_we, ctl_we;
  logic [IDX_W-1:0] ptr_q;
  logic             a_en, b_en;
  logic [IDX_W-1:0] a_idx, b_idx;
  logic [3*CH_W-1:0] a_rgb, b_rgb;

  assign wr_ready = 1'b1;
  assign fire     = wr_valid && wr_ready;
  assign ptr_we   = fire && (loc_e'(wr_sel) == LOC_PTR);
  assign data_we  = fire && (loc_e'(wr_sel) == LOC_DATA);
  assign ctl_we   = fire && (loc_e'(wr_sel) == LOC_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_we) ptr_q <= wr_data[IDX_W-1:0];
  end

  clut_unpack #(.IDX_W(IDX_W), .CH_W(CH_W)) u_unpack (
    .clk(clk), .rst_n(rst_n),
    .ptr_we(ptr_we), .ptr_d(wr_data[IDX_W-1:0]),
    .data_we(data_we), .data_d(wr_data),
    .a_en(a_en), .a_idx(a_idx), .a_rgb(a_rgb),
    .b_en(b_en), .b_idx(b_idx), .b_rgb(b_rgb)
  );

  clut_table #(.IDX_W(IDX_W), .CH_W(CH_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_idx(a_idx), .a_rgb(a_rgb),
    .b_en(b_en), .b_idx(b_idx), .b_rgb(b_rgb),
    .rd_idx(pix_idx), .rd_rgb(pix_rgb)
  );

  clut_cfg #(.IDX_W(IDX_W), .CFG_BASE(4), .CFG_N(4)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .we(ctl_we), .ptr(ptr_q), .d(wr_data[7:0]),
    .rd_sel(cfg_sel), .rd_q(cfg_q)
  );

  p_commit_from_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en || b_en) |-> (wr_valid && wr_sel == 2'd1));

  p_ptr_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel == 2'd0) |=> (ptr_q == $past(wr_data[IDX_W-1:0])));

endmodule

// File: tb/test_clut_pack_loader.sv
`timescale 1ns/1ps
module test_clut_pack_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [7:0]  pix_idx = 8'd0;
  logic [23:0] pix_rgb;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_q;

  int n_vec = 0;
  int n_bad = 0;
  logic [23:0] model [256];
  logic [7:0]  cfg_model [4];

  always #4 clk = ~clk;

  clut_pack_loader i_clut_pack_loader (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .pix_idx(pix_idx), .pix_rgb(pix_rgb),
    .cfg_sel(cfg_sel), .cfg_q(cfg_q)
  );

  function automatic logic [7:0] sb(input int seed, input int k);
    return 8'((k * 37 + seed * 91 + 11) & 255);
  endfunction

  function automatic logic [31:0] wordv(input int seed, input int w);
    return {sb(seed, 4*w), sb(seed, 4*w+1), sb(seed, 4*w+2), sb(seed, 4*w+3)};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d, input logic v);
    @(negedge clk);
    wr_valid = v; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd_chk(input int idx, input string req);
    pix_idx = 8'(idx);
    @(negedge clk);
    check(req, {8'd0, pix_rgb}, {8'd0, model[idx]});
  endtask

  task automatic cfg_chk(input string req);
    for (int i = 0; i < 4; i++) begin
      cfg_sel = 2'(i);
      #1;
      check(req, {24'd0, cfg_q}, {24'd0, cfg_model[i]});
    end
  endtask

  // Word w of a stream started at group base g; entries complete after w+1 words
  task automatic stream_word(input int g, input int seed, input int w);
    wr(2'd1, wordv(seed, w), 1'b1);
    for (int e = 0; 3*e + 2 < 4*(w+1); e++)
      model[(g + e) & 255] = {sb(seed, 3*e), sb(seed, 3*e+1), sb(seed, 3*e+2)};
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 24'd0;
    cfg_model[0] = 8'hFF; cfg_model[1] = 8'h00; cfg_model[2] = 8'h70; cfg_model[3] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents
    for (int i = 0; i < 256; i++) rd_chk(i, "R1 reset entry");
    cfg_chk("R1 reset cfg");
    check("R9 ready", {31'd0, wr_ready}, 32'd1);

    // R2 R4: full table from one pointer write, 192 words, sweep everything
    wr(2'd0, 32'd0, 1'b1);
    for (int w = 0; w < 192; w++) stream_word(0, 1, w);
    for (int i = 0; i < 256; i++) rd_chk(i, "R2 R4 full stream");

    // R3 R4: unaligned pointer, wrap past 255
    wr(2'd0, 32'h0000_00FD, 1'b1);
    for (int w = 0; w < 6; w++) stream_word(252, 2, w);
    for (int i = 250; i < 262; i++) rd_chk(i & 255, "R3 R4 wrap group");

    // R6: entries commit only when complete
    wr(2'd0, 32'h0000_0011, 1'b1);
    stream_word(16, 3, 0);
    rd_chk(16, "R6 first entry after word0");
    rd_chk(17, "R6 second entry held after word0");
    stream_word(16, 3, 1);
    rd_chk(17, "R6 second entry after word1");
    rd_chk(18, "R6 third entry held after word1");

    // R9: cursor location and invalid cycle have no effect
    wr(2'd3, 32'hDEAD_BEEF, 1'b1);
    wr(2'd1, 32'h1234_5678, 1'b0);
    wr(2'd2, 32'h0000_0055, 1'b0);
    for (int i = 16; i < 20; i++) rd_chk(i, "R9 ignored writes table");
    cfg_chk("R9 ignored writes cfg");

    // R5: pointer write discards the partial group
    wr(2'd0, 32'h0000_0020, 1'b1);
    rd_chk(18, "R5 discarded entry 18");
    rd_chk(19, "R5 discarded entry 19");
    stream_word(32, 4, 0);
    stream_word(32, 4, 1);
    wr(2'd3, 32'h0BAD_F00D, 1'b1);   // R9: cursor writes mid-group do not move the cursor
    wr(2'd1, 32'hCAFE_0000, 1'b0);
    stream_word(32, 4, 2);
    for (int i = 31; i < 37; i++) rd_chk(i, "R5 R9 fresh group after rewind");

    // R7: one cycle latency
    @(negedge clk);
    pix_idx = 8'd40;
    @(negedge clk);
    pix_idx = 8'd33;
    #1;
    check("R7 output before edge", {8'd0, pix_rgb}, {8'd0, model[40]});
    @(posedge clk);
    #1;
    check("R7 output after edge", {8'd0, pix_rgb}, {8'd0, model[33]});

    // R8: control file
    wr(2'd0, 32'h0000_0005, 1'b1);
    wr(2'd2, 32'h0000_00A5, 1'b1);
    cfg_model[1] = 8'hA5;
    cfg_chk("R8 write index 5");
    wr(2'd0, 32'h0000_0009, 1'b1);
    wr(2'd2, 32'h0000_0033, 1'b1);
    cfg_chk("R8 index 9 ignored");
    wr(2'd0, 32'h0000_0003, 1'b1);
    wr(2'd2, 32'h0000_0044, 1'b1);
    cfg_chk("R8 index 3 ignored");
    for (int k = 4; k < 8; k++) begin
      wr(2'd0, 32'(k), 1'b1);
      wr(2'd2, 32'(8'h10 + k), 1'b1);
      cfg_model[k-4] = 8'(8'h10 + k);
    end
    cfg_chk("R8 all four indices");
    for (int i = 0; i < 8; i++) rd_chk(i, "R8 table untouched by control");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule